// File: doc/BRIEF.md
# Stimulus Vector Sequencer

This block steps through a small stored program and drives one stimulus vector per rising clock edge. The program has two sections. The first runs once after each start and brings the device under test into a known state. The second follows it and can either run a single time or loop without end.

Besides plain vectors, the program can contain three other instructions. One pauses until a 3-bit external level pattern matches one of four programmable conditions. One pauses until the incoming arm line is high. One raises the outgoing arm line for a single cycle to trigger neighbouring measurement blocks.

The program memory, the four condition masks and the two section bounds are loaded through plain write ports while the sequencer is idle. Playback runs while `start` is held high.

Top module: `stim_seq`

## Requirements
- R1: After reset `vec_out` is zero and `arm_out`, `busy` and `done` are low. All four condition masks reset to zero.
- R2: Each instruction word is `{op[1:0], payload[VEC_W-1:0]}`. Opcode 00 drives the payload onto `vec_out` at the clock edge that executes it. The first instruction executes on the second rising edge after `start` rises from idle.
- R3: With `repeat_en` high, addresses 0 to `init_end` play once after start. After the instruction at `main_end` completes, execution continues at `init_end`+1 and repeats indefinitely.
- R4: Opcode 01 waits on the condition named by `payload[1:0]`. While it waits, `vec_out` holds the last emitted vector. It completes on the first edge at which bit `evt_in` of that condition's 8-bit mask is set, and the next instruction executes on the following edge.
- R5: Four masks are written through `cond_we`/`cond_sel`/`cond_mask`. A wait uses only the selected mask, so inputs matched only by other masks do not release it.
- R6: Opcode 10 waits, holding `vec_out`, until `arm_in` is high at a clock edge.
- R7: Opcode 11 drives its payload onto `vec_out` and raises `arm_out` for exactly one cycle. `arm_out` is never high outside these cycles.
- R8: With `repeat_en` low, completing the instruction at `main_end` stops playback. `done` rises, `busy` falls and `vec_out` holds its value until `start` falls.
- R9: Deasserting `start` returns the block to idle within one edge and clears `done`. The next start replays from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | ADDR_W | Program memory write address |
| prog_data | input | VEC_W+2 | Instruction word to store |
| cond_we | input | 1 | Condition mask write strobe |
| cond_sel | input | 2 | Condition mask being written |
| cond_mask | input | 8 | Mask value; bit k accepts event level k |
| init_end | input | ADDR_W | Last address of the once-only section |
| main_end | input | ADDR_W | Last address of the main section |
| start | input | 1 | Run while high; low forces idle |
| repeat_en | input | 1 | Loop the main section when high |
| evt_in | input | 3 | Level-sensed external event pattern |
| arm_in | input | 1 | Incoming arm condition |
| vec_out | output | VEC_W | Current stimulus vector |
| arm_out | output | 1 | One-cycle outgoing arm pulse |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Single pass finished |

## Verification
The event input is held at a level that only an unselected mask accepts, then at a level the selected mask accepts, and then at a level only a different mask accepts. This separates correct condition selection from a wait that ignores its index. Arm input pulses one cycle wide show whether a wait releases on the exact edge it samples. Runs in looping mode are compared with single-pass runs, and a stop in mid-program is followed by a restart. Together these expose a wrong wrap address, a section replayed more than once, and state carried over from an earlier run.

// File: rtl/stim_seq.sv
module stim_seq #(
  parameter int VEC_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [VEC_W+1:0]  prog_data,
  input  logic              cond_we,
  input  logic [1:0]        cond_sel,
  input  logic [7:0]        cond_mask,
  input  logic [ADDR_W-1:0] init_end,
  input  logic [ADDR_W-1:0] main_end,
  input  logic              start,
  input  logic              repeat_en,
  input  logic [2:0]        evt_in,
  input  logic              arm_in,
  output logic [VEC_W-1:0]  vec_out,
  output logic              arm_out,
  output logic              busy,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int IW    = VEC_W + 2;
  localparam logic [1:0] OP_VEC  = 2'b00;
  localparam logic [1:0] OP_WEVT = 2'b01;
  localparam logic [1:0] OP_WARM = 2'b10;
  localparam logic [1:0] OP_SARM = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] pc;
  logic [IW-1:0]     mem [DEPTH];
  logic [7:0]        mask [4];

  logic [IW-1:0]    instr;
  logic [1:0]       op;
  logic [VEC_W-1:0] payload;
  logic             cond_ok;
  logic             advance;
  logic             at_end;

  assign instr   = mem[pc];
  assign op      = instr[IW-1:VEC_W];
  assign payload = instr[VEC_W-1:0];
  assign cond_ok = mask[payload[1:0]][evt_in];
  assign advance = (op == OP_WEVT) ? cond_ok : (op == OP_WARM) ? arm_in : 1'b1;
  assign at_end  = (pc == main_end);
  assign busy    = (st == S_RUN);

  always_ff @(posedge clk)
    if (prog_we) mem[prog_addr] <= prog_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mask[i] <= '0;
    end else if (cond_we) begin
      mask[cond_sel] <= cond_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pc      <= '0;
      vec_out <= '0;
      arm_out <= 1'b0;
      done    <= 1'b0;
    end else begin
      arm_out <= 1'b0;
      if (!start) begin
        st   <= S_IDLE;
        pc   <= '0;
        done <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            st <= S_RUN;
            pc <= '0;
          end
          S_RUN: begin
            if (op == OP_VEC || op == OP_SARM) vec_out <= payload;
            if (op == OP_SARM) arm_out <= 1'b1;
            if (advance) begin
              if (at_end) begin
                if (repeat_en) pc <= init_end + 1'b1;
                else begin
                  st   <= S_DONE;
                  done <= 1'b1;
                end
              end else begin
                pc <= pc + 1'b1;
              end
            end
          end
          default: st <= S_DONE;
        endcase
      end
    end
  end

  p_hold_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && op == OP_WEVT && !cond_ok) |=> ($stable(vec_out) && busy));

  p_hold_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && op == OP_WARM && !arm_in) |=> ($stable(vec_out) && busy));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && repeat_en && at_end && advance) |=> (pc == ADDR_W'($past(init_end) + 1'b1)));

  p_arm_only_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !arm_out);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !repeat_en && at_end && advance) |=> (done && !busy));

  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!busy && !done && pc == '0));
endmodule

// File: tb/stim_seq_tb.sv
module stim_seq_tb;
  localparam int VW = 16;
  localparam int AW = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic prog_we = 0;
  logic [AW-1:0] prog_addr = '0;
  logic [VW+1:0] prog_data = '0;
  logic cond_we = 0;
  logic [1:0] cond_sel = '0;
  logic [7:0] cond_mask = '0;
  logic [AW-1:0] init_end = '0, main_end = '0;
  logic start = 0, repeat_en = 0, arm_in = 0;
  logic [2:0] evt_in = '0;
  logic [VW-1:0] vec_out;
  logic arm_out, busy, done;

  stim_seq #(.VEC_W(VW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .cond_we(cond_we), .cond_sel(cond_sel),
    .cond_mask(cond_mask), .init_end(init_end), .main_end(main_end),
    .start(start), .repeat_en(repeat_en), .evt_in(evt_in), .arm_in(arm_in),
    .vec_out(vec_out), .arm_out(arm_out), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  logic [VW+1:0] tbmem [64];
  logic [7:0] tbmask [4] = '{default: 8'h00};
  int ms = 0, mpc = 0;
  logic [VW-1:0] mvec = '0;
  bit marm = 0, mdone = 0;

  bit mon = 0;
  int n11 = 0, na0 = 0, narm = 0;
  logic [VW-1:0] prev_vec = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mpc = 0; mvec = '0; marm = 0; mdone = 0;
    end else begin
      marm = 0;
      if (!start) begin
        ms = 0; mpc = 0; mdone = 0;
      end else if (ms == 0) begin
        ms = 1; mpc = 0;
      end else if (ms == 1) begin
        logic [VW+1:0] w;
        bit go;
        w = tbmem[mpc];
        go = 1;
        case (w[VW+1:VW])
          2'd0: mvec = w[VW-1:0];
          2'd3: begin mvec = w[VW-1:0]; marm = 1; end
          2'd1: go = tbmask[w[1:0]][evt_in];
          default: go = arm_in;
        endcase
        if (go) begin
          if (mpc == int'(main_end)) begin
            if (repeat_en) mpc = (int'(init_end) + 1) % 64;
            else begin ms = 2; mdone = 1; end
          end else mpc = (mpc + 1) % 64;
        end
      end
    end
  end

  always begin
    @(posedge clk);
    #5;
    cycles++;
    if (rst_n && !finished) begin
      chk(vec_out == mvec, "R2 vec_out", int'(vec_out), int'(mvec));
      chk(arm_out == marm, "R7 arm_out", int'(arm_out), int'(marm));
      chk(done == mdone, "R8 done", int'(done), int'(mdone));
      chk(busy == (ms == 1), "R9 busy", int'(busy), int'(ms == 1));
      if (mon) begin
        if (vec_out == 16'h0011 && prev_vec != 16'h0011) n11++;
        if (vec_out == 16'h00A0 && prev_vec != 16'h00A0) na0++;
        if (arm_out) narm++;
      end
      prev_vec = vec_out;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [1:0] op, input logic [VW-1:0] pl);
    @(negedge clk);
    prog_we = 1; prog_addr = AW'(a); prog_data = {op, pl};
    tbmem[a] = {op, pl};
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic wm(input int s, input logic [7:0] m);
    @(negedge clk);
    cond_we = 1; cond_sel = 2'(s); cond_mask = m;
    tbmask[s] = m;
    @(negedge clk);
    cond_we = 0;
  endtask

  initial begin
    while (cycles < 20000 && !finished) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) tbmem[i] = '0;
    tick(3);
    chk(vec_out == 0 && !arm_out && !busy && !done, "R1 reset outputs",
        {vec_out, arm_out, busy, done}, 0);
    rst_n = 1;
    tick(1);
    wr(0, 2'd0, 16'h0011);
    wr(1, 2'd3, 16'h0022);
    wr(2, 2'd0, 16'h0033);
    wr(3, 2'd0, 16'h00A0);
    wr(4, 2'd1, 16'h0001);
    wr(5, 2'd0, 16'h00A1);
    wr(6, 2'd2, 16'h0000);
    for (int i = 7; i < 64; i++) wr(i, 2'd0, 16'(16'hF000 + i));
    wm(0, 8'h01);
    wm(1, 8'h24);
    init_end = 2; main_end = 6;
    repeat_en = 1;

    // looping run
    mon = 1;
    start = 1;
    tick(2);
    chk(vec_out == 16'h0011, "R2 first vector two edges after start", int'(vec_out), 16'h0011);
    tick(20);
    chk(vec_out == 16'h00A0 && busy, "R4 holds during wait", int'(vec_out), 16'h00A0);
    chk(vec_out == 16'h00A0, "R5 unselected mask 0 does not release", int'(vec_out), 16'h00A0);
    evt_in = 3'd5; tick(2); evt_in = 3'd0; tick(5);
    chk(vec_out == 16'h00A1, "R4 release on matching level", int'(vec_out), 16'h00A1);
    chk(vec_out == 16'h00A1 && busy, "R6 holds before arm", int'(vec_out), 16'h00A1);
    for (int k = 0; k < 3; k++) begin
      arm_in = 1; tick(1); arm_in = 0; tick(5);
      chk(vec_out == 16'h00A0, "R6 arm releases and R3 wraps", int'(vec_out), 16'h00A0);
      evt_in = 3'd2; tick(1); evt_in = 3'd0; tick(5);
    end
    chk(n11 == 1, "R3 init section played once", n11, 1);
    chk(na0 == 4, "R3 main section repeated", na0, 4);
    chk(narm == 1, "R7 one arm pulse per send", narm, 1);
    mon = 0;

    // stop and single pass
    start = 0; tick(2);
    chk(!busy && !done, "R9 idle after stop", {busy, done}, 0);
    repeat_en = 0; evt_in = 3'd5; arm_in = 1;
    start = 1; tick(20);
    chk(done && !busy, "R8 done after single pass", {done, busy}, 2);
    chk(vec_out == 16'h00A1, "R8 output holds after done", int'(vec_out), 16'h00A1);
    tick(5);
    chk(done && vec_out == 16'h00A1, "R8 stays stopped", int'(vec_out), 16'h00A1);
    start = 0; arm_in = 0; evt_in = 3'd0; tick(1);
    chk(!done, "R9 stop clears done", int'(done), 0);

    // restart replays from address 0
    repeat_en = 1; start = 1; tick(2);
    chk(vec_out == 16'h0011, "R9 restart from address 0", int'(vec_out), 16'h0011);
    start = 0; tick(2);

    // condition index selection
    wr(4, 2'd1, 16'h0002);
    wm(2, 8'h80);
    evt_in = 3'd5; start = 1; tick(20);
    chk(vec_out == 16'h00A0 && busy, "R5 mask 1 level ignored by cond 2", int'(vec_out), 16'h00A0);
    evt_in = 3'd7; tick(3);
    chk(vec_out == 16'h00A1, "R5 cond 2 released by level 7", int'(vec_out), 16'h00A1);
    start = 0; evt_in = 3'd0; tick(3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule